// File: doc/BRIEF.md
# LFSR-Counted Raster Timing Generator

This block produces the raster timing for a display pipe: horizontal sync, vertical sync, a data-enable that marks visible pixels, and a one-cycle pulse at the first pixel of each frame. Its pixel and line counters are 16-bit maximal-length LFSRs instead of binary counters. A step is a single shift plus one XOR, so there is no carry chain in the pixel-rate path. Every programmed position is therefore the LFSR state reached after the intended number of steps from the all-ones start value, not a plain integer. Configuration software performs that conversion and presents the resulting states on the register inputs. The block only compares for equality.

Each axis counts from its all-ones start value. The horizontal counter returns to all-ones after it matches the line end value, and that same event moves the vertical counter on by one step. Windows for sync and for the visible region open at one match and close at another. A 2-bit blanking control selects one of three modes: normal video, blanked video with the syncs still running, or power-down with everything held quiet.

Top module: `lfsr_vtg`

## Requirements
- R1: Both counters start at 16'hFFFF (count 0). One step shifts the state left by one bit, and the new bit 0 is the XOR of old bits 15, 4, 2 and 1. Every register input holds the state reached after N such steps, where N is the intended count.
- R2: A line lasts hEndCount+1 pixel clocks, where hEndCount is the count whose state is programmed on `hEndCountLfsr`. A frame lasts vEndCount+1 lines.
- R3: In the clock after the horizontal counter equals `hEndCountLfsr`, the horizontal counter is back at 16'hFFFF, and the vertical counter has moved on by exactly one step.
- R4: The vertical counter changes only at a horizontal wrap. When a horizontal wrap happens while the vertical counter equals `vEndCountLfsr`, the vertical counter returns to 16'hFFFF.
- R5: `hsyncO` is high for the pixels whose count c satisfies hSyncStart <= c < hSyncEnd. Every output appears one clock after the counter state it describes.
- R6: `vsyncO` is high on the lines whose count satisfies vSyncStart <= line < vSyncEnd.
- R7: `deO` is high only when the pixel lies inside [hDispStart, hDispEnd) and the line lies inside [vDispStart, vDispEnd) at the same time.
- R8: `frameStartO` is high for exactly one clock: the one that describes pixel 0 of line 0.
- R9: With `blankMode` = 2'b01, `deO` stays low. `hsyncO`, `vsyncO` and `frameStartO` keep their normal timing.
- R10: With `blankMode[1]` = 1 (2'b10 or 2'b11), the clock edge drives every output low and holds both counters at 16'hFFFF. On return to 2'b00 the raster restarts from pixel 0 of line 0.
- R11: While `rstN` is low, every output is low and both counters sit at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hDispStartLfsr | input | 16 | LFSR state of first visible pixel |
| hDispEndLfsr | input | 16 | LFSR state of first pixel after the visible span |
| vDispStartLfsr | input | 16 | LFSR state of first visible line |
| vDispEndLfsr | input | 16 | LFSR state of first line after the visible span |
| hEndCountLfsr | input | 16 | LFSR state of the last pixel of a line |
| hSyncStartLfsr | input | 16 | LFSR state where horizontal sync rises |
| hSyncEndLfsr | input | 16 | LFSR state where horizontal sync falls |
| vEndCountLfsr | input | 16 | LFSR state of the last line of a frame |
| vSyncStartLfsr | input | 16 | LFSR state where vertical sync rises |
| vSyncEndLfsr | input | 16 | LFSR state where vertical sync falls |
| blankMode | input | 2 | 00 video, 01 blanked video, 1x power-down |
| hsyncO | output | 1 | Horizontal sync |
| vsyncO | output | 1 | Vertical sync |
| deO | output | 1 | Data enable (visible pixel) |
| frameStartO | output | 1 | One-clock pulse at pixel 0 of line 0 |

## Verification
The bench targets timings where a visible span ends exactly on the last pixel of a line or the last line of a frame. A design with the wrong compare priority there would carry data-enable over into the next line or frame. Vertical sync starts on line 0, the same line the wrap produces, so a vertical counter that stepped at the wrong moment shifts vsync by one line. Power-down is entered in mid-frame and then released. A design that resumed from the frozen count, or that kept a stale window flag, would misplace the frame-start pulse or open sync early. Blanked-video runs show whether data-enable is suppressed while the syncs keep their timing.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;

  typedef enum logic [1:0] {
    BLANK_OFF   = 2'b00,
    BLANK_VIDEO = 2'b01,
    BLANK_PD_A  = 2'b10,
    BLANK_PD_B  = 2'b11
  } blankMode_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic hold;     // power-down: both counters at seed
    logic hReload;  // horizontal wrap
    logic vStep;    // vertical advance by one step
    logic vReload;  // vertical wrap
  } ctrStrobe_t;

  localparam int NUM_WIN   = 4;
  localparam int WIN_HSYNC = 0;
  localparam int WIN_HDISP = 1;
  localparam int WIN_VSYNC = 2;
  localparam int WIN_VDISP = 3;

endpackage

// File: rtl/vtg_lfsr_ctr.sv
`timescale 1ns/1ps
module vtg_lfsr_ctr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    TAPS = 16'h8016
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic         reload,
  input  logic         advance,
  output logic [W-1:0] state
);

  localparam logic [W-1:0] SEED = '1;

  logic feedback;
  assign feedback = ^(state & TAPS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               state <= SEED;
    else if (hold || reload) state <= SEED;
    else if (advance)        state <= {state[W-2:0], feedback};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    state != '0) else $error("counter reached the lock-up state"); // R1

  AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (!rstN)
    (hold || reload) |=> state == SEED) else $error("seed not reloaded"); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!hold && !reload && !advance) |=> $stable(state)) else $error("counter moved without a step"); // R4

endmodule

// File: rtl/vtg_window.sv
`timescale 1ns/1ps
module vtg_window #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic [W-1:0] state,
  input  logic [W-1:0] openAt,
  input  logic [W-1:0] closeAt,
  output logic         flagNext
);

  logic flag;

  // Open match wins over close match; flag holds between matches
  always_comb begin
    if (clear)                 flagNext = 1'b0;
    else if (state == openAt)  flagNext = 1'b1;
    else if (state == closeAt) flagNext = 1'b0;
    else                       flagNext = flag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= flagNext;
  end

endmodule

// File: rtl/vtg_datapath.sv
`timescale 1ns/1ps
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] TAPS = 16'h8016
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrStrobe_t   strobe,
  output logic [W-1:0] hState,
  output logic [W-1:0] vState
);

  localparam int NUM_AXIS = 2;

  logic [NUM_AXIS-1:0] axReload;
  logic [NUM_AXIS-1:0] axAdvance;
  logic [W-1:0]        axState [NUM_AXIS];

  assign axReload  = {strobe.vReload, strobe.hReload};
  assign axAdvance = {strobe.vStep, 1'b1};

  generate
    for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
      vtg_lfsr_ctr #(.W(W), .TAPS(TAPS)) u_ctr (
        .clk     (clk),
        .rstN    (rstN),
        .hold    (strobe.hold),
        .reload  (axReload[a]),
        .advance (axAdvance[a]),
        .state   (axState[a])
      );
    end
  endgenerate

  assign hState = axState[0];
  assign vState = axState[1];

  AST_V_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.hReload && !strobe.hold) |=> $stable(vState)) else $error("line counter moved mid-line"); // R4

endmodule

// File: rtl/vtg_control.sv
`timescale 1ns/1ps
module vtg_control
  import vtg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] hState,
  input  logic [W-1:0] vState,
  input  logic [W-1:0] hDispStart,
  input  logic [W-1:0] hDispEnd,
  input  logic [W-1:0] vDispStart,
  input  logic [W-1:0] vDispEnd,
  input  logic [W-1:0] hEndCount,
  input  logic [W-1:0] hSyncStart,
  input  logic [W-1:0] hSyncEnd,
  input  logic [W-1:0] vEndCount,
  input  logic [W-1:0] vSyncStart,
  input  logic [W-1:0] vSyncEnd,
  input  logic [1:0]   blankMode,
  output ctrStrobe_t   strobe,
  output logic         hsyncO,
  output logic         vsyncO,
  output logic         deO,
  output logic         frameStartO
);

  localparam logic [W-1:0] SEED = '1;

  logic powerDown, videoOn, hAtEnd, vAtEnd, atOrigin;
  assign powerDown = blankMode[1];
  assign videoOn   = (blankMode_e'(blankMode) == BLANK_OFF);
  assign hAtEnd    = (hState == hEndCount);
  assign vAtEnd    = (vState == vEndCount);
  assign atOrigin  = (hState == SEED) && (vState == SEED);

  always_comb begin
    strobe.hold    = powerDown;
    strobe.hReload = hAtEnd;
    strobe.vStep   = hAtEnd && !vAtEnd;
    strobe.vReload = hAtEnd && vAtEnd;
  end

  // Window table: which axis and which compare pair
  logic [W-1:0]       winState [NUM_WIN];
  logic [W-1:0]       winOpen  [NUM_WIN];
  logic [W-1:0]       winClose [NUM_WIN];
  logic [NUM_WIN-1:0] winNext;

  always_comb begin
    winState[WIN_HSYNC] = hState; winOpen[WIN_HSYNC] = hSyncStart; winClose[WIN_HSYNC] = hSyncEnd;
    winState[WIN_HDISP] = hState; winOpen[WIN_HDISP] = hDispStart; winClose[WIN_HDISP] = hDispEnd;
    winState[WIN_VSYNC] = vState; winOpen[WIN_VSYNC] = vSyncStart; winClose[WIN_VSYNC] = vSyncEnd;
    winState[WIN_VDISP] = vState; winOpen[WIN_VDISP] = vDispStart; winClose[WIN_VDISP] = vDispEnd;
  end

  generate
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      vtg_window #(.W(W)) u_win (
        .clk      (clk),
        .rstN     (rstN),
        .clear    (powerDown),
        .state    (winState[i]),
        .openAt   (winOpen[i]),
        .closeAt  (winClose[i]),
        .flagNext (winNext[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncO      <= 1'b0;
      vsyncO      <= 1'b0;
      deO         <= 1'b0;
      frameStartO <= 1'b0;
    end else begin
      hsyncO      <= winNext[WIN_HSYNC];
      vsyncO      <= winNext[WIN_VSYNC];
      deO         <= videoOn && winNext[WIN_HDISP] && winNext[WIN_VDISP];
      frameStartO <= !powerDown && atOrigin;
    end
  end

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (!hsyncO && !vsyncO && !deO && !frameStartO)) else $error("output active in power-down"); // R10

  AST_DE_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (!rstN)
    deO |-> ($past(blankMode) == 2'b00)) else $error("data enable while blanked"); // R9

endmodule

// File: rtl/lfsr_vtg.sv
`timescale 1ns/1ps
module lfsr_vtg
  import vtg_pkg::*;
#(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] TAPS = 16'h8016
) (
  input  logic         pixClk,
  input  logic         rstN,
  input  logic [W-1:0] hDispStartLfsr,
  input  logic [W-1:0] hDispEndLfsr,
  input  logic [W-1:0] vDispStartLfsr,
  input  logic [W-1:0] vDispEndLfsr,
  input  logic [W-1:0] hEndCountLfsr,
  input  logic [W-1:0] hSyncStartLfsr,
  input  logic [W-1:0] hSyncEndLfsr,
  input  logic [W-1:0] vEndCountLfsr,
  input  logic [W-1:0] vSyncStartLfsr,
  input  logic [W-1:0] vSyncEndLfsr,
  input  logic [1:0]   blankMode,
  output logic         hsyncO,
  output logic         vsyncO,
  output logic         deO,
  output logic         frameStartO
);

  ctrStrobe_t   strobe;
  logic [W-1:0] hState;
  logic [W-1:0] vState;

  vtg_control #(.W(W)) u_control (
    .clk         (pixClk),
    .rstN        (rstN),
    .hState      (hState),
    .vState      (vState),
    .hDispStart  (hDispStartLfsr),
    .hDispEnd    (hDispEndLfsr),
    .vDispStart  (vDispStartLfsr),
    .vDispEnd    (vDispEndLfsr),
    .hEndCount   (hEndCountLfsr),
    .hSyncStart  (hSyncStartLfsr),
    .hSyncEnd    (hSyncEndLfsr),
    .vEndCount   (vEndCountLfsr),
    .vSyncStart  (vSyncStartLfsr),
    .vSyncEnd    (vSyncEndLfsr),
    .blankMode   (blankMode),
    .strobe      (strobe),
    .hsyncO      (hsyncO),
    .vsyncO      (vsyncO),
    .deO         (deO),
    .frameStartO (frameStartO)
  );

  vtg_datapath #(.W(W), .TAPS(TAPS)) u_datapath (
    .clk    (pixClk),
    .rstN   (rstN),
    .strobe (strobe),
    .hState (hState),
    .vState (vState)
  );

endmodule

// File: tb/lfsr_vtg_bench.sv
`timescale 1ns/1ps
module lfsr_vtg_bench;

  logic        pixClk = 1'b0;
  logic        rstN   = 1'b0;
  logic [15:0] hDS = '1, hDE = '1, vDS = '1, vDE = '1, hEC = '1;
  logic [15:0] hSS = '1, hSE = '1, vEC = '1, vSS = '1, vSE = '1;
  logic [1:0]  blankMode = 2'b00;
  logic        hsyncO, vsyncO, deO, frameStartO;

  lfsr_vtg u_lfsr_vtg (
    .pixClk(pixClk), .rstN(rstN),
    .hDispStartLfsr(hDS), .hDispEndLfsr(hDE),
    .vDispStartLfsr(vDS), .vDispEndLfsr(vDE),
    .hEndCountLfsr(hEC), .hSyncStartLfsr(hSS), .hSyncEndLfsr(hSE),
    .vEndCountLfsr(vEC), .vSyncStartLfsr(vSS), .vSyncEndLfsr(vSE),
    .blankMode(blankMode),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .frameStartO(frameStartO)
  );

  always #10 pixClk = ~pixClk;

  int vecs = 0, errs = 0;
  bit done = 0;
  // integer timing (counts), model position
  int hTot, hSwid, hSyncPos, hAct, vTot, vSwid, vSyncPos, vAct;
  int hEndN, hsS, hsE, hdS, hdE, vEndN, vsS, vsE, vdS, vdE;
  int mh, mv;

  // Reference conversion of a count into the counter state (R1)
  function automatic logic [15:0] lfsrOf(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  function automatic bit inWin(input int c, input int s, input int e);
    return (c >= s) && (c < e);
  endfunction

  task automatic expect1(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b (pixel %0d line %0d)", tag, act, exp, mh, mv);
    end
  endtask

  task automatic checkCycle();
    logic eH, eV, eD, eF;
    string sTag;
    if (blankMode[1]) begin
      expect1("R10 hsync", hsyncO, 1'b0);
      expect1("R10 vsync", vsyncO, 1'b0);
      expect1("R10 de", deO, 1'b0);
      expect1("R10 frameStart", frameStartO, 1'b0);
      mh = 0; mv = 0;
    end else begin
      eH = inWin(mh, hsS, hsE);
      eV = inWin(mv, vsS, vsE);
      eD = (blankMode == 2'b00) && inWin(mh, hdS, hdE) && inWin(mv, vdS, vdE);
      eF = (mh == 0) && (mv == 0);
      sTag = (blankMode == 2'b01) ? "R9 " : "";
      expect1({sTag, "R1 R5 hsync"}, hsyncO, eH);
      expect1({sTag, "R4 R6 vsync"}, vsyncO, eV);
      expect1((blankMode == 2'b01) ? "R9 de" : "R7 de", deO, eD);
      expect1({sTag, "R2 R3 R8 frameStart"}, frameStartO, eF);
      if (mh == hEndN) begin
        mh = 0;
        if (mv == vEndN) mv = 0; else mv++;
      end else mh++;
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge pixClk);
      @(negedge pixClk);
      checkCycle();
    end
  endtask

  task automatic startCfg();
    @(negedge pixClk);
    rstN = 1'b0;
    blankMode = 2'b00;
    hEndN = hTot - 1; hsS = 1; hsE = hSwid + 1;
    hdS = hTot - hSyncPos; hdE = hdS + hAct;
    vEndN = vTot; vsS = 0; vsE = vSwid;
    vdS = vTot - vSyncPos; vdE = vdS + vAct;
    hEC = lfsrOf(hEndN); hSS = lfsrOf(hsS); hSE = lfsrOf(hsE);
    hDS = lfsrOf(hdS);   hDE = lfsrOf(hdE);
    vEC = lfsrOf(vEndN); vSS = lfsrOf(vsS); vSE = lfsrOf(vsE);
    vDS = lfsrOf(vdS);   vDE = lfsrOf(vdE);
    for (int k = 0; k < 2; k++) begin
      @(negedge pixClk);
      expect1("R11 hsync", hsyncO, 1'b0);
      expect1("R11 vsync", vsyncO, 1'b0);
      expect1("R11 de", deO, 1'b0);
      expect1("R11 frameStart", frameStartO, 1'b0);
    end
    rstN = 1'b1;
    mh = 0; mv = 0;
  endtask

  task automatic randCfg();
    hAct = 4 + int'($urandom % 20); hSwid = 1 + int'($urandom % 4);
    hSyncPos = hAct + 1 + int'($urandom % 3);
    hTot = hSyncPos + hSwid + 2 + int'($urandom % 6);
    vAct = 2 + int'($urandom % 6); vSwid = 1 + int'($urandom % 2);
    vSyncPos = vAct + int'($urandom % 3);
    vTot = vSyncPos + vSwid + 1 + int'($urandom % 4);
  endtask

  initial begin
    void'($urandom(32'h1F0E_5EED));
    // Directed: visible span ends on the last pixel and on the last line
    hAct = 8; hSwid = 2; hSyncPos = 9; hTot = 16;
    vAct = 3; vSwid = 1; vSyncPos = 3; vTot = 6;
    startCfg();
    cycles(2 * hTot * (vTot + 1) + 3);
    // Blanked video, then back to video (R9)
    blankMode = 2'b01;
    cycles(150);
    blankMode = 2'b00;
    cycles(60);
    // Power-down mid-frame, both encodings, then restart (R10)
    blankMode = 2'b10;
    cycles(20);
    blankMode = 2'b11;
    cycles(5);
    blankMode = 2'b00;
    cycles(2 * hTot * (vTot + 1));
    // Random timings
    for (int c = 0; c < 6; c++) begin
      randCfg();
      startCfg();
      cycles(2 * hTot * (vTot + 1) + 3);
      if (c == 2) begin
        blankMode = 2'b10;
        cycles(7);
        blankMode = 2'b00;
        cycles(hTot * (vTot + 1) + 2);
      end
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL R2 watchdog: got unfinished run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule